// File: doc/BRIEF.md
# Display RAM Address Counter with Selectable Scan Direction

This block produces the write address for a byte-wide display memory arranged as a grid of banks and columns: five banks, each eight display lines tall, by 101 columns. One column byte holds eight vertically stacked pixels. Bit 0 is the top line of its bank and bit 7 is the bottom line. The serial front end that decodes bus traffic feeds the block with three strobes:

- a control-byte load, which carries a bank number and a scan-direction bit;
- a pointer-byte load, which carries a column number;
- a per-byte write strobe with the data.

The block passes each data byte to the memory with a write enable. It presents the bank and column at which that byte lands. It then moves the pointer by one position.

In horizontal mode the column is the fast index: bytes fill a bank from left to right, then continue in the next bank. In vertical mode the bank is the fast index: bytes fill one column from bank 0 to bank 4, then continue in the next column. Both indices wrap, so a stream of 505 bytes covers the whole memory once and returns to the origin. Out-of-range load values fall back to zero, so the pointer never leaves the array.

Top module: `dispAddrCounter`

## Requirements
- R1: After reset the pointer is bank 0, column 0, the scan mode is horizontal and `ramWe` is 0.
- R2: A `loadCtrl` pulse sets the bank to `ctrlBank` (values 0 to 4) and sets the scan mode from `ctrlVert` (0 horizontal, 1 vertical). The new values are visible from the next clock edge.
- R3: A `loadCtrl` pulse with `ctrlBank` of 5, 6 or 7 sets the bank to 0.
- R4: A `loadCol` pulse sets the column to `colIn` when `colIn` is 0 to 100. A value of 101 to 127 sets the column to 0.
- R5: While `wrStrobe` is high, `ramWe` is high in the same cycle and `ramData` equals `wrData`. `ramBank` and `ramCol` give the address of that byte.
- R6: In horizontal mode, a write at a column below 100 advances the column by one and leaves the bank unchanged.
- R7: In horizontal mode, a write at column 100 sets the column to 0 and advances the bank by one. Bank 4 wraps to bank 0.
- R8: In vertical mode, a write at a bank below 4 advances the bank by one and leaves the column unchanged.
- R9: In vertical mode, a write at bank 4 sets the bank to 0 and advances the column by one. Column 100 wraps to column 0.
- R10: With no load and no write, the pointer holds its value.
- R11: When a load pulse and `wrStrobe` occur in the same cycle, the byte is written at the address held before the load. The loaded field then takes the loaded value, and no advance is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadCtrl | input | 1 | Control-byte load strobe |
| ctrlBank | input | 3 | Bank number carried by the control byte |
| ctrlVert | input | 1 | Scan direction carried by the control byte (1 = vertical) |
| loadCol | input | 1 | Pointer-byte load strobe |
| colIn | input | 7 | Column number carried by the pointer byte |
| wrStrobe | input | 1 | One data byte to be written this cycle |
| wrData | input | 8 | Data byte |
| ramWe | output | 1 | Write enable to the display memory |
| ramBank | output | 3 | Bank index of the current write |
| ramCol | output | 7 | Column index of the current write |
| ramData | output | 8 | Data byte to the display memory |

## Verification
The bench drives short write bursts that start just before a wrap point in each mode. Bursts starting at column 98 and at bank 2 show whether the fast index and the slow index are swapped, and whether a carry reaches the slow index at the right moment. Starting at the far corner (bank 4, column 100) in both modes checks that both indices return to the origin together.

A full 505-byte vertical sweep is compared against a bench-side model of the scan order, so any skipped or repeated address shows up. Loads with out-of-range values, idle cycles, and loads that coincide with a write separate correct clamping, holding and priority from a pointer that drifts or advances after a reload.

// File: rtl/dispAddrPkg.sv
package dispAddrPkg;

  // Strobes sent from the control section to the address datapath
  typedef struct packed {
    logic loadBank;  // take the bank from the control byte
    logic loadCol;   // take the column from the pointer byte
    logic advance;   // step the pointer by one position
  } addrCmdT;

endpackage

// File: rtl/dispAddrCtrl.sv
module dispAddrCtrl
  import dispAddrPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadCtrl,
  input  logic    ctrlVert,
  input  logic    loadCol,
  input  logic    wrStrobe,
  output addrCmdT cmd,
  output logic    vertMode,
  output logic    writeEn
);

  logic anyLoad;
  logic modeReg;

  assign anyLoad = loadCtrl | loadCol;

  // Scan direction is stored with the control byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= 1'b0;
    end else if (loadCtrl) begin
      modeReg <= ctrlVert;
    end
  end

  // A load in the same cycle as a write takes priority over the advance
  always_comb begin
    cmd          = '0;
    cmd.loadBank = rstN & loadCtrl;
    cmd.loadCol  = rstN & loadCol;
    cmd.advance  = rstN & wrStrobe & ~anyLoad;
  end

  assign writeEn  = rstN & wrStrobe;
  assign vertMode = modeReg;

endmodule

// File: rtl/dispAddrPath.sv
module dispAddrPath
  import dispAddrPkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int NUM_COLS  = 101,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrCmdT           cmd,
  input  logic              vertMode,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [COL_W-1:0]  colIn,
  output logic [BANK_W-1:0] bankPtr,
  output logic [COL_W-1:0]  colPtr
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);

  logic [BANK_W-1:0] bankReg, bankNext, bankStep, bankLoadVal;
  logic [COL_W-1:0]  colReg,  colNext,  colStep,  colLoadVal;
  logic              bankAtEnd, colAtEnd;
  logic              bankMove, colMove;

  assign bankAtEnd = (bankReg == LAST_BANK);
  assign colAtEnd  = (colReg == LAST_COL);

  // Wrapping single-step values for each index
  assign bankStep = bankAtEnd ? '0 : bankReg + 1'b1;
  assign colStep  = colAtEnd  ? '0 : colReg + 1'b1;

  // Values beyond the array fall back to zero
  assign bankLoadVal = (bankIn <= LAST_BANK) ? bankIn : '0;
  assign colLoadVal  = (colIn <= LAST_COL) ? colIn : '0;

  // The fast index always moves; the slow one moves on the fast one's wrap
  generate
    if (NUM_BANKS > 1) begin : gMultiBank
      always_comb begin
        if (vertMode) begin
          bankMove = 1'b1;
          colMove  = bankAtEnd;
        end else begin
          colMove  = 1'b1;
          bankMove = colAtEnd;
        end
      end
    end else begin : gSingleBank
      always_comb begin
        bankMove = 1'b0;
        colMove  = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    bankNext = bankReg;
    colNext  = colReg;
    if (cmd.advance) begin
      if (bankMove) bankNext = bankStep;
      if (colMove)  colNext  = colStep;
    end
    if (cmd.loadBank) bankNext = bankLoadVal;
    if (cmd.loadCol)  colNext  = colLoadVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg <= '0;
      colReg  <= '0;
    end else begin
      bankReg <= bankNext;
      colReg  <= colNext;
    end
  end

  assign bankPtr = bankReg;
  assign colPtr  = colReg;

endmodule

// File: rtl/dispAddrCounter.sv
module dispAddrCounter
  import dispAddrPkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int NUM_COLS  = 101,
  parameter int DATA_W    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadCtrl,
  input  logic [BANK_W-1:0] ctrlBank,
  input  logic              ctrlVert,
  input  logic              loadCol,
  input  logic [COL_W-1:0]  colIn,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              ramWe,
  output logic [BANK_W-1:0] ramBank,
  output logic [COL_W-1:0]  ramCol,
  output logic [DATA_W-1:0] ramData
);

  addrCmdT cmd;
  logic    vertMode;
  logic    writeEn;

  dispAddrCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadCtrl (loadCtrl),
    .ctrlVert (ctrlVert),
    .loadCol  (loadCol),
    .wrStrobe (wrStrobe),
    .cmd      (cmd),
    .vertMode (vertMode),
    .writeEn  (writeEn)
  );

  dispAddrPath #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_COLS  (NUM_COLS)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .vertMode (vertMode),
    .bankIn   (ctrlBank),
    .colIn    (colIn),
    .bankPtr  (ramBank),
    .colPtr   (ramCol)
  );

  assign ramWe   = writeEn;
  assign ramData = wrData;

endmodule

// File: rtl/dispAddrChecker.sv
module dispAddrChecker #(
  parameter int NUM_BANKS = 5,
  parameter int NUM_COLS  = 101,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadCtrl,
  input logic              loadCol,
  input logic              wrStrobe,
  input logic              vertMode,
  input logic              ramWe,
  input logic [BANK_W-1:0] ramBank,
  input logic [COL_W-1:0]  ramCol
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);

  logic plainWrite;
  logic idle;
  assign plainWrite = wrStrobe & ~loadCtrl & ~loadCol;
  assign idle       = ~wrStrobe & ~loadCtrl & ~loadCol;

  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramBank <= LAST_BANK); // R3
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramCol <= LAST_COL); // R4
  AST_WE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ramWe == wrStrobe); // R5
  AST_HORZ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (plainWrite && !vertMode && ramCol != LAST_COL)
      |=> (ramCol == COL_W'($past(ramCol) + 1'b1)) && $stable(ramBank)); // R6
  AST_HORZ_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (plainWrite && !vertMode && ramCol == LAST_COL)
      |=> (ramCol == '0) && (ramBank == (($past(ramBank) == LAST_BANK) ? '0
                                         : BANK_W'($past(ramBank) + 1'b1)))); // R7
  AST_VERT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (plainWrite && vertMode && ramBank != LAST_BANK)
      |=> (ramBank == BANK_W'($past(ramBank) + 1'b1)) && $stable(ramCol)); // R8
  AST_VERT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (plainWrite && vertMode && ramBank == LAST_BANK)
      |=> (ramBank == '0) && (ramCol == (($past(ramCol) == LAST_COL) ? '0
                                         : COL_W'($past(ramCol) + 1'b1)))); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> $stable(ramBank) && $stable(ramCol)); // R10
  AST_LOAD_NO_STEP_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && loadCol && !loadCtrl) |=> $stable(ramBank)); // R11

endmodule

bind dispAddrCounter dispAddrChecker #(
  .NUM_BANKS (NUM_BANKS),
  .NUM_COLS  (NUM_COLS)
) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .loadCtrl (loadCtrl),
  .loadCol  (loadCol),
  .wrStrobe (wrStrobe),
  .vertMode (vertMode),
  .ramWe    (ramWe),
  .ramBank  (ramBank),
  .ramCol   (ramCol)
);

// File: tb/dispAddrCounter_test.sv
module dispAddrCounter_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int NC = 101;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadCtrl = 1'b0;
  logic [2:0] ctrlBank = '0;
  logic       ctrlVert = 1'b0;
  logic       loadCol = 1'b0;
  logic [6:0] colIn = '0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       ramWe;
  logic [2:0] ramBank;
  logic [6:0] ramCol;
  logic [7:0] ramData;

  int errors = 0;
  int checks = 0;
  int expBank = 0;
  int expCol = 0;
  bit expVert = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dispAddrCounter uut (
    .clk      (clk),
    .rstN     (rstN),
    .loadCtrl (loadCtrl),
    .ctrlBank (ctrlBank),
    .ctrlVert (ctrlVert),
    .loadCol  (loadCol),
    .colIn    (colIn),
    .wrStrobe (wrStrobe),
    .wrData   (wrData),
    .ramWe    (ramWe),
    .ramBank  (ramBank),
    .ramCol   (ramCol),
    .ramData  (ramData)
  );

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkPtr(string req);
    checkVal(req, "bank", int'(ramBank), expBank);
    checkVal(req, "column", int'(ramCol), expCol);
  endtask

  // Advance the bench model of the pointer by one written byte
  task automatic modelStep();
    if (expVert) begin
      if (expBank == NB - 1) begin
        expBank = 0;
        expCol = (expCol == NC - 1) ? 0 : expCol + 1;
      end else expBank++;
    end else begin
      if (expCol == NC - 1) begin
        expCol = 0;
        expBank = (expBank == NB - 1) ? 0 : expBank + 1;
      end else expCol++;
    end
  endtask

  task automatic doLoadCtrl(int b, bit v);
    @(negedge clk);
    loadCtrl = 1'b1; ctrlBank = 3'(b); ctrlVert = v;
    @(negedge clk);
    loadCtrl = 1'b0;
    expBank = (b < NB) ? b : 0;
    expVert = v;
  endtask

  task automatic doLoadCol(int c);
    @(negedge clk);
    loadCol = 1'b1; colIn = 7'(c);
    @(negedge clk);
    loadCol = 1'b0;
    expCol = (c < NC) ? c : 0;
  endtask

  task automatic writeByte(string req, logic [7:0] d);
    @(negedge clk);
    wrStrobe = 1'b1; wrData = d;
    #1;
    checkVal("R5", "ramWe", int'(ramWe), 1);
    checkVal("R5", "ramData", int'(ramData), int'(d));
    checkPtr(req);
    @(negedge clk);
    wrStrobe = 1'b0;
    modelStep();
  endtask

  task automatic testReset();
    checkVal("R1", "bank", int'(ramBank), 0);
    checkVal("R1", "column", int'(ramCol), 0);
    checkVal("R1", "ramWe", int'(ramWe), 0);
    writeByte("R1", 8'h11);
    checkVal("R1", "horizontal default column", int'(ramCol), 1);
    checkVal("R1", "horizontal default bank", int'(ramBank), 0);
  endtask

  task automatic testLoads();
    doLoadCtrl(3, 1'b0);
    checkPtr("R2");
    doLoadCtrl(6, 1'b0);
    checkVal("R3", "bank for 6", int'(ramBank), 0);
    doLoadCtrl(4, 1'b0);
    doLoadCtrl(7, 1'b0);
    checkVal("R3", "bank for 7", int'(ramBank), 0);
    doLoadCol(57);
    checkVal("R4", "column 57", int'(ramCol), 57);
    doLoadCol(100);
    checkVal("R4", "column 100", int'(ramCol), 100);
    doLoadCol(120);
    checkVal("R4", "column for 120", int'(ramCol), 0);
  endtask

  task automatic testHorizontal();
    doLoadCtrl(0, 1'b0);
    doLoadCol(98);
    checkVal("R2", "bank 0", int'(ramBank), 0);
    for (int i = 0; i < 5; i++) writeByte("R6", 8'(8'h20 + i));
    checkVal("R7", "bank after row wrap", int'(ramBank), 1);
    checkVal("R7", "column after row wrap", int'(ramCol), 2);
    doLoadCtrl(4, 1'b0);
    doLoadCol(100);
    writeByte("R7", 8'h5A);
    checkVal("R7", "corner bank", int'(ramBank), 0);
    checkVal("R7", "corner column", int'(ramCol), 0);
  endtask

  task automatic testVertical();
    doLoadCtrl(2, 1'b1);
    doLoadCol(10);
    for (int i = 0; i < 3; i++) writeByte("R8", 8'(8'h40 + i));
    checkVal("R9", "bank after column wrap", int'(ramBank), 0);
    checkVal("R9", "column after column wrap", int'(ramCol), 11);
    writeByte("R8", 8'h44);
    checkVal("R8", "bank 1 same column", int'(ramBank), 1);
    checkVal("R8", "column held", int'(ramCol), 11);
    doLoadCtrl(4, 1'b1);
    doLoadCol(100);
    writeByte("R9", 8'hA5);
    checkVal("R9", "corner bank", int'(ramBank), 0);
    checkVal("R9", "corner column", int'(ramCol), 0);
  endtask

  task automatic testIdle();
    doLoadCtrl(3, 1'b0);
    doLoadCol(44);
    repeat (6) @(negedge clk);
    checkVal("R10", "bank held", int'(ramBank), 3);
    checkVal("R10", "column held", int'(ramCol), 44);
  endtask

  task automatic testCollision();
    doLoadCtrl(1, 1'b0);
    doLoadCol(5);
    @(negedge clk);
    wrStrobe = 1'b1; wrData = 8'h77; loadCol = 1'b1; colIn = 7'd40;
    #1;
    checkVal("R11", "write column before load", int'(ramCol), 5);
    checkVal("R11", "ramWe", int'(ramWe), 1);
    @(negedge clk);
    wrStrobe = 1'b0; loadCol = 1'b0;
    checkVal("R11", "loaded column", int'(ramCol), 40);
    checkVal("R11", "bank not stepped", int'(ramBank), 1);
    @(negedge clk);
    wrStrobe = 1'b1; loadCtrl = 1'b1; ctrlBank = 3'd3; ctrlVert = 1'b1;
    #1;
    checkVal("R11", "write bank before load", int'(ramBank), 1);
    @(negedge clk);
    wrStrobe = 1'b0; loadCtrl = 1'b0;
    checkVal("R11", "loaded bank", int'(ramBank), 3);
    checkVal("R11", "column not stepped", int'(ramCol), 40);
    expBank = 3; expCol = 40; expVert = 1'b1;
  endtask

  task automatic testFullSweep();
    doLoadCtrl(0, 1'b1);
    doLoadCol(0);
    for (int i = 0; i < NB * NC; i++) writeByte("R9", 8'(i));
    checkVal("R9", "sweep returns bank", int'(ramBank), 0);
    checkVal("R9", "sweep returns column", int'(ramCol), 0);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoads();
    testHorizontal();
    testVertical();
    testIdle();
    testCollision();
    testFullSweep();
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

endmodule